// File: doc/BRIEF.md
# Five-Phase Micro-Sequencer

This block walks a 64-word micro-program store and spreads every micro-instruction over five phases: fetch, decode, execute, memory access and advance. In each phase in which the sequencer moves forward, it raises a one-hot phase strobe that the datapath uses to time its own actions. When the advance phase ends, the block picks the following micro-address. It can fall through to the next word, jump unconditionally, or jump only when the datapath's zero or negative flag is set.

Progress is controlled by a free-run level and three single-cycle step requests. A phase step moves forward by one phase. A micro step runs to the next fetch. An instruction step runs until the sequencer reaches fetch at micro-address 0, which is where the machine-instruction fetch routine begins. The micro-program store is filled through a valid/ready write port. The port is ready only while the sequencer is idle. A write is accepted in a cycle where valid and ready are both high. While ready is low, the writer must hold its address and data until the handshake completes. A write offered while ready is low has no effect.

Top module: `useq_core`

## Requirements
- R1: While reset is active and in the first cycle after it, the micro-address is 0, the phase is fetch (code 0), the control word is all zeros and the load port is ready.
- R2: Phase codes are fetch=0, decode=1, execute=2, memory=3, advance=4. Each cycle in which the sequencer advances moves the phase to the next code, and advance wraps to fetch.
- R3: If free-run is low, no step request is present and no step burst is in progress, the phase and micro-address hold.
- R4: A phase step request taken while idle advances exactly one phase.
- R5: A micro step request taken while idle, in any phase, advances on every cycle until the sequencer reaches the next fetch, and then stops.
- R6: An instruction step request taken while idle advances on every cycle until the sequencer enters fetch with micro-address 0.
- R7: Leaving fetch latches the store word at the current micro-address into the control word. That value holds through advance and the following fetch.
- R8: Branch field bits 24:23 = 0 (next) sets the micro-address to the current address plus one, modulo 64, so 63 is followed by 0.
- R9: Branch field = 1 (jump) loads the next-address field, bits 22:17 of the control word.
- R10: Branch field = 2 takes the next-address field when the zero flag is high in the advance cycle, and otherwise takes address plus one.
- R11: Branch field = 3 does the same as R10, using the negative flag.
- R12: The micro-address changes only on the cycle in which advance ends.
- R13: The phase strobe output is one-hot for the current phase in any cycle in which the sequencer advances, and all zeros otherwise.
- R14: Load-port ready is low while free-run is high or a step burst is in progress. Only a write with valid and ready both high changes the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| free_run | input | 1 | Advance one phase per clock while high |
| step_phase | input | 1 | Request one phase step |
| step_micro | input | 1 | Request a run to the next fetch |
| step_instr | input | 1 | Request a run to fetch at address 0 |
| flag_zero | input | 1 | Datapath zero flag |
| flag_neg | input | 1 | Datapath negative flag |
| ld_valid | input | 1 | Store write offered |
| ld_ready | output | 1 | Store write can be accepted |
| ld_addr | input | 6 | Store write address |
| ld_data | input | 25 | Store write word |
| uaddr | output | 6 | Current micro-address |
| phase | output | 3 | Current phase code |
| ctrl_word | output | 25 | Latched control word |
| phase_fire | output | 5 | One-hot strobe of the phase that completes |

## Verification
The assertions check on every cycle that the phase order holds, that the strobe is one-hot, that the micro-address moves only at the end of advance, that the control word holds outside fetch, that ready drops during free-run, and that each branch kind picks the address its rule gives. Only the bench can show where each step request stops, that a refused write leaves the store untouched, and that the control word matches what was loaded. These need a reference model of the store and of the burst state.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_EXEC   = 3'd2,
    PH_MEM    = 3'd3,
    PH_ADV    = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    BR_NEXT = 2'd0,
    BR_JUMP = 2'd1,
    BR_ZERO = 2'd2,
    BR_NEG  = 2'd3
  } branch_e;

  localparam int NUM_PHASES = 5;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int AW = 6,
  parameter int CW = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [CW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (wr_en) begin
      words[wr_addr] <= wr_data;
    end
  end

  assign rd_data = words[rd_addr];
endmodule

// File: rtl/useq_runctl.sv
module useq_runctl
  import useq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   free_run,
  input  logic   step_phase,
  input  logic   step_micro,
  input  logic   step_instr,
  input  logic   next_is_zero,
  output phase_e phase,
  output logic   adv,
  output logic   wrap,
  output logic   busy
);
  logic burst_micro, burst_instr;
  logic any_step;
  phase_e phase_nx;

  assign busy     = free_run | burst_micro | burst_instr;
  assign any_step = step_phase | step_micro | step_instr;
  assign adv      = busy | any_step;
  assign wrap     = adv && (phase == PH_ADV);

  always_comb begin
    unique case (phase)
      PH_FETCH:  phase_nx = PH_DECODE;
      PH_DECODE: phase_nx = PH_EXEC;
      PH_EXEC:   phase_nx = PH_MEM;
      PH_MEM:    phase_nx = PH_ADV;
      default:   phase_nx = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_FETCH;
      burst_micro <= 1'b0;
      burst_instr <= 1'b0;
    end else begin
      if (adv) phase <= phase_nx;
      if (!busy) begin
        if (step_instr)      burst_instr <= !(wrap && next_is_zero);
        else if (step_micro) burst_micro <= !wrap;
      end else begin
        if (burst_instr && wrap && next_is_zero) burst_instr <= 1'b0;
        if (burst_micro && wrap)                 burst_micro <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/useq_addr.sv
module useq_addr
  import useq_pkg::*;
#(
  parameter int AW     = 6,
  parameter int NA_LSB = 17,
  parameter int CW     = NA_LSB + AW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrap,
  input  logic [CW-1:0] ctrl,
  input  logic          flag_zero,
  input  logic          flag_neg,
  output logic [AW-1:0] uaddr,
  output logic [AW-1:0] next_addr
);
  localparam int BR_LSB = NA_LSB + AW;

  branch_e       kind;
  logic [AW-1:0] target;
  logic [AW-1:0] seq;

  assign kind   = branch_e'(ctrl[BR_LSB +: 2]);
  assign target = ctrl[NA_LSB +: AW];
  assign seq    = uaddr + AW'(1);

  always_comb begin
    unique case (kind)
      BR_NEXT: next_addr = seq;
      BR_JUMP: next_addr = target;
      BR_ZERO: next_addr = flag_zero ? target : seq;
      default: next_addr = flag_neg  ? target : seq;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    uaddr <= '0;
    else if (wrap) uaddr <= next_addr;
  end
endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter int AW     = 6,
  parameter int NA_LSB = 17,
  parameter int CW     = NA_LSB + AW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          free_run,
  input  logic          step_phase,
  input  logic          step_micro,
  input  logic          step_instr,
  input  logic          flag_zero,
  input  logic          flag_neg,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_data,
  output logic [AW-1:0] uaddr,
  output logic [2:0]    phase,
  output logic [CW-1:0] ctrl_word,
  output logic [NUM_PHASES-1:0] phase_fire
);
  phase_e        ph;
  logic          adv, wrap, busy;
  logic [CW-1:0] rd_word;
  logic [AW-1:0] next_addr;

  useq_store #(.AW(AW), .CW(CW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ld_valid && ld_ready),
    .wr_addr (ld_addr),
    .wr_data (ld_data),
    .rd_addr (uaddr),
    .rd_data (rd_word)
  );

  useq_runctl u_run (
    .clk          (clk),
    .rst_n        (rst_n),
    .free_run     (free_run),
    .step_phase   (step_phase),
    .step_micro   (step_micro),
    .step_instr   (step_instr),
    .next_is_zero (next_addr == '0),
    .phase        (ph),
    .adv          (adv),
    .wrap         (wrap),
    .busy         (busy)
  );

  useq_addr #(.AW(AW), .NA_LSB(NA_LSB), .CW(CW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrap      (wrap),
    .ctrl      (ctrl_word),
    .flag_zero (flag_zero),
    .flag_neg  (flag_neg),
    .uaddr     (uaddr),
    .next_addr (next_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                      ctrl_word <= '0;
    else if (adv && ph == PH_FETCH)  ctrl_word <= rd_word;
  end

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_fire
    assign phase_fire[g] = adv && (ph == phase_e'(g));
  end

  assign ld_ready = !busy;
  assign phase    = ph;
endmodule

// File: rtl/useq_core_chk.sv
module useq_core_chk #(
  parameter int AW     = 6,
  parameter int NA_LSB = 17,
  parameter int CW     = NA_LSB + AW + 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          free_run,
  input logic          flag_zero,
  input logic          flag_neg,
  input logic          ld_ready,
  input logic [AW-1:0] uaddr,
  input logic [2:0]    phase,
  input logic [CW-1:0] ctrl_word,
  input logic [4:0]    phase_fire
);
  localparam int BR_LSB = NA_LSB + AW;

  logic [1:0]    br;
  logic [AW-1:0] na;
  assign br = ctrl_word[BR_LSB +: 2];
  assign na = ctrl_word[NA_LSB +: AW];

  p_phase_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 3'd4);
  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_fire != 5'd0 && phase != 3'd4) |=> phase == $past(phase) + 3'd1);
  p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_fire[4] |=> phase == 3'd0);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_fire == 5'd0 |=> $stable(phase) && $stable(uaddr));
  p_ctrl_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_fire[0] |=> $stable(ctrl_word));
  p_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_fire[4] && br == 2'd0) |=> uaddr == AW'($past(uaddr) + 1'b1));
  p_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_fire[4] && br == 2'd1) |=> uaddr == $past(na));
  p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_fire[4] && br == 2'd2) |=>
      uaddr == ($past(flag_zero) ? $past(na) : AW'($past(uaddr) + 1'b1)));
  p_neg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_fire[4] && br == 2'd3) |=>
      uaddr == ($past(flag_neg) ? $past(na) : AW'($past(uaddr) + 1'b1)));
  p_addr_only_adv_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_fire[4] |=> $stable(uaddr));
  p_fire_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase_fire));
  p_fire_matches_r13: assert property (@(posedge clk) disable iff (!rst_n)
    phase_fire != 5'd0 |-> phase_fire[phase]);
  p_ready_free_r14: assert property (@(posedge clk) disable iff (!rst_n)
    free_run |-> !ld_ready);
endmodule

bind useq_core useq_core_chk #(.AW(AW), .NA_LSB(NA_LSB), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .free_run   (free_run),
  .flag_zero  (flag_zero),
  .flag_neg   (flag_neg),
  .ld_ready   (ld_ready),
  .uaddr      (uaddr),
  .phase      (phase),
  .ctrl_word  (ctrl_word),
  .phase_fire (phase_fire)
);

// File: tb/tb_useq_core.sv
module tb_useq_core;
  localparam int AW = 6;
  localparam int CW = 25;

  logic clk = 1'b0;
  logic rst_n;
  logic free_run, step_phase, step_micro, step_instr, flag_zero, flag_neg;
  logic ld_valid, ld_ready;
  logic [AW-1:0] ld_addr, uaddr;
  logic [CW-1:0] ld_data, ctrl_word;
  logic [2:0] phase;
  logic [4:0] phase_fire;

  always #5 clk = ~clk;

  useq_core dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [CW-1:0] m_mem [64];
  logic [CW-1:0] m_ctrl;
  logic [AW-1:0] m_addr;
  int m_ph;
  bit m_bm, m_bi;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] mk(input logic [1:0] br, input logic [5:0] na, input logic [16:0] lo);
    return {br, na, lo};
  endfunction

  function automatic logic [AW-1:0] calc_next(input logic [CW-1:0] w, input logic [AW-1:0] a,
                                              input logic z, input logic n);
    logic [AW-1:0] inc = a + 6'd1;
    case (w[24:23])
      2'd0: return inc;
      2'd1: return w[22:17];
      2'd2: return z ? w[22:17] : inc;
      default: return n ? w[22:17] : inc;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    m_ctrl = '0; m_addr = '0; m_ph = 0; m_bm = 0; m_bi = 0;
  endtask

  // one clock: inputs already driven at a falling edge
  task automatic tick();
    bit busy, adv, wrap, sany;
    logic [AW-1:0] nx;
    #1;
    busy = free_run | m_bm | m_bi;
    sany = step_phase | step_micro | step_instr;
    adv  = busy | sany;
    wrap = adv && (m_ph == 4);
    nx   = calc_next(m_ctrl, m_addr, flag_zero, flag_neg);
    chk(ld_ready == !busy, "R14 ready", ld_ready, !busy);
    chk(phase_fire == (adv ? 5'(1 << m_ph) : 5'd0), "R13 strobe", phase_fire,
        adv ? 5'(1 << m_ph) : 5'd0);
    if (adv && m_ph == 0) m_ctrl = m_mem[m_addr];
    if (wrap) m_addr = nx;
    if (adv) m_ph = (m_ph == 4) ? 0 : m_ph + 1;
    if (!busy) begin
      if (step_instr) m_bi = !(wrap && nx == 0);
      else if (step_micro) m_bm = !wrap;
    end else begin
      if (m_bi && wrap && nx == 0) m_bi = 0;
      if (m_bm && wrap) m_bm = 0;
    end
    if (ld_valid && !busy) m_mem[ld_addr] = ld_data;
    @(posedge clk);
    @(negedge clk);
    chk(phase == 3'(m_ph), "R2 phase", phase, m_ph);
    chk(uaddr == m_addr, "R8 address", uaddr, m_addr);
    chk(ctrl_word == m_ctrl, "R7 control word", ctrl_word, m_ctrl);
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [CW-1:0] d);
    ld_valid = 1; ld_addr = a; ld_data = d;
    tick();
    ld_valid = 0;
  endtask

  task automatic run_micro();
    step_micro = 1; tick(); step_micro = 0;
    for (int i = 0; i < 4; i++) tick();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_1234));
    rst_n = 0; free_run = 0; step_phase = 0; step_micro = 0; step_instr = 0;
    flag_zero = 0; flag_neg = 0; ld_valid = 0; ld_addr = '0; ld_data = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk(uaddr == 0, "R1 uaddr", uaddr, 0);
    chk(phase == 0, "R1 phase", phase, 0);
    chk(ctrl_word == 0, "R1 ctrl", ctrl_word, 0);
    chk(ld_ready == 1, "R1 ready", ld_ready, 1);

    // program: 0 jump 5; 5 if-zero 10; 10 jump 5; 6 if-neg 20; 20 jump 6; 7 jump 63; 63 next
    load(6'd0,  mk(2'd1, 6'd5,  17'h0A5A5));
    load(6'd5,  mk(2'd2, 6'd10, 17'h00111));
    load(6'd10, mk(2'd1, 6'd5,  17'h00222));
    load(6'd6,  mk(2'd3, 6'd20, 17'h00333));
    load(6'd20, mk(2'd1, 6'd6,  17'h00444));
    load(6'd7,  mk(2'd1, 6'd63, 17'h00555));
    load(6'd63, mk(2'd0, 6'd9,  17'h00666));

    // R3: hold
    repeat (4) tick();
    chk(phase == 0 && uaddr == 0, "R3 hold", {phase, uaddr}, 0);

    // R4: single phase steps, R12 address unchanged mid-instruction
    step_phase = 1; tick(); step_phase = 0; tick();
    chk(phase == 1, "R4 one phase", phase, 1);
    chk(ctrl_word == mk(2'd1, 6'd5, 17'h0A5A5), "R7 latched word", ctrl_word, mk(2'd1, 6'd5, 17'h0A5A5));
    for (int i = 0; i < 3; i++) begin step_phase = 1; tick(); step_phase = 0; end
    chk(phase == 4 && uaddr == 0, "R12 address held", uaddr, 0);
    step_phase = 1; tick(); step_phase = 0;
    chk(uaddr == 5 && phase == 0, "R9 jump", uaddr, 5);

    // R10 taken
    flag_zero = 1; run_micro();
    chk(uaddr == 10 && phase == 0, "R10 zero taken", uaddr, 10);
    chk(ld_ready == 1, "R5 stop at fetch", ld_ready, 1);
    run_micro();
    chk(uaddr == 5, "R9 jump back", uaddr, 5);
    // R5 from mid-instruction, R10 not taken
    flag_zero = 0;
    step_phase = 1; tick(); tick(); step_phase = 0;
    step_micro = 1; tick(); step_micro = 0; tick(); tick();
    chk(uaddr == 6 && phase == 0, "R5 mid start / R10 not taken", uaddr, 6);
    tick();
    chk(phase == 0, "R5 stopped", phase, 0);
    flag_neg = 1; run_micro();
    chk(uaddr == 20, "R11 neg taken", uaddr, 20);
    run_micro(); flag_neg = 0; run_micro();
    chk(uaddr == 7, "R11 neg not taken", uaddr, 7);
    run_micro(); run_micro();
    chk(uaddr == 0, "R8 wrap 63 to 0", uaddr, 0);

    // R6: instruction step 0->5->6->7->63->0
    step_instr = 1; tick(); step_instr = 0; n = 1;
    while (m_bi && n < 200) begin tick(); n++; end
    chk(n == 25, "R6 cycle count", n, 25);
    chk(uaddr == 0 && phase == 0 && ld_ready == 1, "R6 stop", uaddr, 0);

    // R14: refused write during free run
    free_run = 1; #1;
    chk(ld_ready == 0, "R14 busy", ld_ready, 0);
    ld_valid = 1; ld_addr = 6'd0; ld_data = mk(2'd1, 6'd33, 17'h1);
    repeat (10) tick();
    ld_valid = 0; free_run = 0;
    while (m_ph != 0) begin step_phase = 1; tick(); end
    step_phase = 0;
    while (m_addr != 0) run_micro();
    step_phase = 1; tick(); step_phase = 0;
    chk(ctrl_word == mk(2'd1, 6'd5, 17'h0A5A5), "R14 write ignored", ctrl_word, mk(2'd1, 6'd5, 17'h0A5A5));

    // constrained random
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom_range(0, 99);
      free_run   = (k / 200) % 2 == 1 && r < 90;
      step_phase = r >= 90 && r < 94;
      step_micro = r >= 94 && r < 97;
      step_instr = r == 97;
      flag_zero  = $urandom_range(0, 1);
      flag_neg   = $urandom_range(0, 1);
      ld_valid   = $urandom_range(0, 3) == 0;
      ld_addr    = AW'($urandom);
      ld_data    = CW'($urandom);
      tick();
    end
    free_run = 0; step_phase = 0; step_micro = 0; step_instr = 0; ld_valid = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule